// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block gathers up to 63 interrupt requests, numbered 1 to 63, and tells the processor the most urgent level that is currently asking for service. Each source carries a pending bit, a mask bit, a software force bit and a control field that gives it a level (1 to 7) and one of nine ranks inside that level. The block keeps the highest unmasked, pending level on a 3-bit output. It returns the vector of the winning source when the processor reads the acknowledge register of a level.

All access goes through one plain register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`, and reading has no side effects. There is no valid/ready stream here: the request lines, the level output and the register port are all plain control and status pins with no back-pressure. Sources 1 to 7 are fixed at a level equal to their own number and sit at the middle rank of that level. Every other source is programmed by software.

Top module: `vec_intc`

## Requirements
- R1: After reset every mask bit is 1, every force bit and control field is 0, and `irq_level` is 0. The mask words read 0xFFFFFFFE at address 0x02 and 0xFFFFFFFF at address 0x03.
- R2: The pending bit of source n is the OR of its request input and its force bit, registered one clock later. Request line `irq_req[k]` belongs to source k+1. The pending words are at 0x00 (sources 1..31, bit n = source n, bit 0 reads 0) and 0x01 (bit n-32 = source n). Writes to these addresses are ignored.
- R3: A mask bit of 1 keeps its source out of `irq_level` and out of every acknowledge, while its pending bit stays readable. The mask words are written at 0x02 and 0x03, laid out as the pending words.
- R4: The force words at 0x04 and 0x05 use the same layout. A force bit of 1 holds its source pending with no request input. Once the force bit is cleared, the pending bit follows the request input again from the next clock.
- R5: The control field of source n (n ≥ 8) is at 0x40+n. Bits [5:3] hold the level and bits [2:0] the priority, and the field reads back as written. A level of 0 means the source never takes part in arbitration.
- R6: Sources 1 to 7 ignore control writes and read back their source number in bits [5:3] and 0 in bits [2:0]. Inside a level, the nine ranks from lowest to highest are: priority 0..3, then a fixed source, then priority 4..7.
- R7: `irq_level` is the highest level among unmasked pending sources with a nonzero level, or 0 when there is none.
- R8: Reading address 0x08+L, for L from 1 to 7, returns 64+n, where n is the winning unmasked pending source at level L.
- R9: Two sources with the same level and the same rank are resolved in favour of the higher source number.
- R10: An acknowledge read that finds no eligible source returns the spurious vector 24.
- R11: Reading address 0x08 (software acknowledge) returns the vector of the overall winner. The overall winner has the highest level, then the highest rank, then the highest number. The read returns 24 when nothing is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Request lines; bit k is source k+1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq_level | output | 3 | Encoded level of the most urgent eligible request |

## Verification
The bench builds the block with its defaults: NUM_SRC = 63, ADDR_W = 8 and DATA_W = 32. With these values the pending, mask and force vectors span two words, so sources in the upper word, including source 63 at the top bit, can be reached. These values also give room for a fixed source and programmed sources to meet in one level, on both sides of the middle rank. With them, ties, forced requests hidden behind a mask and a level-0 source can all be driven while other levels stay active.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int LVL_W      = 3;
  localparam int PRI_W      = 3;
  localparam int RANK_W     = 4;
  localparam int NUM_LVL    = 8;             // slot 0 = overall winner
  localparam int FIXED_SRCS = 7;
  localparam int MID_RANK   = 2 ** (PRI_W - 1);
  localparam int VEC_BASE   = 64;
  localparam int SPUR_VEC   = 24;

  localparam int PEND_ADDR  = 'h00;
  localparam int MASK_ADDR  = 'h02;
  localparam int FRC_ADDR   = 'h04;
  localparam int ACK_ADDR   = 'h08;
  localparam int CTRL_ADDR  = 'h40;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [PRI_W-1:0] pri;
  } ctrl_t;

  // programmed priority to rank: the upper half steps over the fixed midpoint
  function automatic logic [RANK_W-1:0] rank_of(input logic [PRI_W-1:0] pri);
    if (pri >= PRI_W'(MID_RANK)) return RANK_W'(pri) + RANK_W'(1);
    return RANK_W'(pri);
  endfunction
endpackage

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_req,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [NUM_SRC:0]     pend_o,
  output logic [NUM_SRC:0]     mask_o,
  output logic [NUM_SRC:0]     frc_o,
  output ctrl_t [NUM_SRC:0]    ctrl_o
);
  localparam int NWORDS = (NUM_SRC + DATA_W) / DATA_W;
  localparam int TOT    = NWORDS * DATA_W;
  localparam logic [TOT-1:0] ONE   = TOT'(1);
  localparam logic [TOT-1:0] VALID = ((ONE << (NUM_SRC + 1)) - ONE) & ~ONE;

  logic [TOT-1:0] mask_r, frc_r, pend_r, req_w;
  assign req_w = TOT'({irq_req, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= VALID;
      frc_r  <= '0;
      pend_r <= '0;
    end else begin
      pend_r <= (req_w | frc_r) & VALID;
      for (int w = 0; w < NWORDS; w++) begin
        if (reg_wr && reg_addr == ADDR_W'(MASK_ADDR + w))
          mask_r[w*DATA_W +: DATA_W] <= reg_wdata & VALID[w*DATA_W +: DATA_W];
        if (reg_wr && reg_addr == ADDR_W'(FRC_ADDR + w))
          frc_r[w*DATA_W +: DATA_W] <= reg_wdata & VALID[w*DATA_W +: DATA_W];
      end
    end
  end

  assign pend_o = pend_r[NUM_SRC:0];
  assign mask_o = mask_r[NUM_SRC:0];
  assign frc_o  = frc_r[NUM_SRC:0];

  ctrl_t ctrl_a [NUM_SRC+1];

  for (genvar n = 0; n <= NUM_SRC; n++) begin : g_ctrl
    if (n == 0) begin : g_none
      assign ctrl_a[n] = '0;
    end else if (n <= FIXED_SRCS) begin : g_fixed
      assign ctrl_a[n] = ctrl_t'({LVL_W'(n), PRI_W'(0)});
    end else begin : g_prog
      ctrl_t r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR + n))
          r <= ctrl_t'(reg_wdata[LVL_W+PRI_W-1:0]);
      end
      assign ctrl_a[n] = r;
    end
  end

  always_comb begin
    for (int n = 0; n <= NUM_SRC; n++) ctrl_o[n] = ctrl_a[n];
  end
endmodule

// File: rtl/vec_intc_arb.sv
module vec_intc_arb
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:0]                  pend_i,
  input  logic [NUM_SRC:0]                  mask_i,
  input  ctrl_t [NUM_SRC:0]                 ctrl_i,
  output logic [NUM_LVL-1:0]                win_vld_o,
  output logic [NUM_LVL-1:0][SRC_W-1:0]     win_src_o,
  output logic [LVL_W-1:0]                  irq_level_o
);
  localparam int KEY_W = RANK_W + SRC_W;

  // key = {rank, number}: unique per source, nonzero for any real source
  function automatic logic [KEY_W-1:0] key_of(input int n, input ctrl_t c);
    logic [RANK_W-1:0] rk;
    rk = (n <= FIXED_SRCS) ? RANK_W'(MID_RANK) : rank_of(c.pri);
    return {rk, SRC_W'(n)};
  endfunction

  logic [NUM_SRC:0] act;
  assign act = pend_i & ~mask_i;

  logic             lvl_vld [1:NUM_LVL-1];
  logic [SRC_W-1:0] lvl_src [1:NUM_LVL-1];

  for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
    logic [KEY_W-1:0] best;
    always_comb begin
      best = '0;
      for (int n = 1; n <= NUM_SRC; n++) begin
        if (act[n] && ctrl_i[n].lvl == LVL_W'(l) && key_of(n, ctrl_i[n]) > best)
          best = key_of(n, ctrl_i[n]);
      end
    end
    assign lvl_vld[l] = (best != '0);
    assign lvl_src[l] = best[SRC_W-1:0];
  end

  always_comb begin
    irq_level_o  = '0;
    win_vld_o    = '0;
    win_src_o    = '0;
    for (int l = 1; l < NUM_LVL; l++) begin
      win_vld_o[l] = lvl_vld[l];
      win_src_o[l] = lvl_src[l];
      if (lvl_vld[l]) begin
        irq_level_o  = LVL_W'(l);
        win_vld_o[0] = 1'b1;
        win_src_o[0] = lvl_src[l];
      end
    end
  end
endmodule

// File: rtl/vec_intc_rdmux.sv
module vec_intc_rdmux
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int SRC_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [NUM_SRC:0]               pend_i,
  input  logic [NUM_SRC:0]               mask_i,
  input  logic [NUM_SRC:0]               frc_i,
  input  ctrl_t [NUM_SRC:0]              ctrl_i,
  input  logic [NUM_LVL-1:0]             win_vld_i,
  input  logic [NUM_LVL-1:0][SRC_W-1:0]  win_src_i,
  output logic [DATA_W-1:0]              reg_rdata
);
  localparam int NWORDS = (NUM_SRC + DATA_W) / DATA_W;
  localparam int TOT    = NWORDS * DATA_W;

  logic [TOT-1:0] pend_p, mask_p, frc_p;
  assign pend_p = TOT'(pend_i);
  assign mask_p = TOT'(mask_i);
  assign frc_p  = TOT'(frc_i);

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (reg_addr == ADDR_W'(PEND_ADDR + w)) reg_rdata = pend_p[w*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(MASK_ADDR + w)) reg_rdata = mask_p[w*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(FRC_ADDR + w))  reg_rdata = frc_p[w*DATA_W +: DATA_W];
    end
    for (int l = 0; l < NUM_LVL; l++) begin
      if (reg_addr == ADDR_W'(ACK_ADDR + l))
        reg_rdata = win_vld_i[l] ? DATA_W'(VEC_BASE + int'(win_src_i[l]))
                                 : DATA_W'(SPUR_VEC);
    end
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (reg_addr == ADDR_W'(CTRL_ADDR + n)) reg_rdata = DATA_W'(ctrl_i[n]);
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [LVL_W-1:0]   irq_level
);
  localparam int SRC_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:0]              pend, mask, frc;
  ctrl_t [NUM_SRC:0]             ctrl;
  logic [NUM_LVL-1:0]            win_vld;
  logic [NUM_LVL-1:0][SRC_W-1:0] win_src;

  vec_intc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pend_o(pend), .mask_o(mask), .frc_o(frc), .ctrl_o(ctrl)
  );

  vec_intc_arb #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
    .pend_i(pend), .mask_i(mask), .ctrl_i(ctrl),
    .win_vld_o(win_vld), .win_src_o(win_src), .irq_level_o(irq_level)
  );

  vec_intc_rdmux #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_rdmux (
    .reg_addr(reg_addr), .pend_i(pend), .mask_i(mask), .frc_i(frc), .ctrl_i(ctrl),
    .win_vld_i(win_vld), .win_src_i(win_src), .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 63,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [LVL_W-1:0]  irq_level
);
  // R1: with all masks set out of reset, no level is presented
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> irq_level == '0);

  // R8: the acknowledge of the presented level always finds a source
  a_r8_level_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0 && reg_addr == ADDR_W'(ACK_ADDR + int'(irq_level)))
      |-> reg_rdata != DATA_W'(SPUR_VEC));

  // R8: any non-spurious acknowledge lies in the vector range of real sources
  a_r8_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= ADDR_W'(ACK_ADDR) && reg_addr < ADDR_W'(ACK_ADDR + NUM_LVL)
      && reg_rdata != DATA_W'(SPUR_VEC))
      |-> (reg_rdata > DATA_W'(VEC_BASE) && reg_rdata <= DATA_W'(VEC_BASE + NUM_SRC)));

  // R10: a level above the presented one has nothing to acknowledge
  a_r10_above_level_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(ACK_ADDR + int'(irq_level)) && reg_addr < ADDR_W'(ACK_ADDR + NUM_LVL))
      |-> reg_rdata == DATA_W'(SPUR_VEC));

  // R11: software acknowledge is spurious exactly when no level is presented
  a_r11_sw_ack_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(ACK_ADDR))
      |-> ((reg_rdata == DATA_W'(SPUR_VEC)) == (irq_level == '0)));
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_level(irq_level)
);

// File: tb/test_vec_intc.sv
module test_vec_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 63;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            reg_wr = 1'b0;
  logic [7:0]      reg_addr = 8'h20;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [2:0]      irq_level;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_intc i_vec_intc (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_level(irq_level)
  );

  typedef struct {
    bit          is_lvl;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // driver side: present a read address and queue what it must return
  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    sb.push_back('{is_lvl: 1'b0, exp: e, tag: tag});
  endtask

  task automatic exp_lvl(input logic [2:0] e, input string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 8'h20;
    sb.push_back('{is_lvl: 1'b1, exp: 32'(e), tag: tag});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0; reg_addr = 8'h20;
  endtask

  task automatic set_req(input int src, input bit v);
    @(negedge clk);
    irq_req[src-1] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor side: compare in the low phase, away from any edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_lvl ? 32'(irq_level) : reg_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    exp_lvl(3'd0, "R1 level after reset");
    exp_rd(8'h02, 32'hFFFF_FFFE, "R1 mask low");
    exp_rd(8'h03, 32'hFFFF_FFFF, "R1 mask high");
    exp_rd(8'h04, 32'h0, "R1 force low");
    exp_rd(8'h4A, 32'h0, "R1 ctrl source 10");
    exp_rd(8'h00, 32'h0, "R1 pending low");
    exp_rd(8'h0B, 32'd24, "R10 level 3 idle");
    exp_rd(8'h08, 32'd24, "R11 sw ack idle");

    // R2 / R3 request while masked
    set_req(3, 1'b1);
    exp_rd(8'h00, 32'h0000_0008, "R2 pending src3");
    exp_lvl(3'd0, "R3 masked src3 not presented");
    exp_rd(8'h0B, 32'd24, "R3 masked src3 not acked");
    wr(8'h00, 32'h0);
    exp_rd(8'h00, 32'h0000_0008, "R2 pending write ignored");

    // R7 / R8 unmask
    wr(8'h02, 32'hFFFF_FFF6);
    exp_lvl(3'd3, "R7 level 3");
    exp_rd(8'h0B, 32'd67, "R8 ack level 3 src3");
    exp_rd(8'h08, 32'd67, "R11 sw ack src3");

    // R5 / R6 programmed source in the same level
    wr(8'h54, 32'h0000_001D);
    exp_rd(8'h54, 32'd29, "R5 ctrl src20 readback");
    set_req(20, 1'b1);
    wr(8'h02, 32'hFFEF_FFF6);
    exp_rd(8'h0B, 32'd84, "R6 prio 5 beats fixed midpoint");
    wr(8'h54, 32'h0000_001B);
    exp_rd(8'h0B, 32'd67, "R6 fixed midpoint beats prio 3");
    wr(8'h43, 32'h0000_003F);
    exp_rd(8'h43, 32'd24, "R6 fixed ctrl write ignored");
    exp_rd(8'h0B, 32'd67, "R6 src3 still level 3 winner");

    // R9 tie in level 5
    wr(8'h68, 32'h0000_002A);
    wr(8'h72, 32'h0000_002A);
    set_req(40, 1'b1);
    set_req(50, 1'b1);
    wr(8'h03, 32'hFFFB_FEFF);
    exp_lvl(3'd5, "R7 level 5");
    exp_rd(8'h0D, 32'd114, "R9 tie higher number wins");
    exp_rd(8'h08, 32'd114, "R11 sw ack picks level 5");
    exp_rd(8'h0B, 32'd67, "R8 level 3 unaffected");

    // R4 force, hidden by mask then revealed
    wr(8'h7F, 32'h0000_0038);
    wr(8'h05, 32'h8000_0000);
    idle(1);
    exp_rd(8'h01, 32'h8004_0100, "R4 forced src63 pending");
    exp_lvl(3'd5, "R3 forced src63 masked");
    wr(8'h03, 32'h7FFB_FEFF);
    exp_lvl(3'd7, "R4 forced src63 level 7");
    exp_rd(8'h0F, 32'd127, "R8 ack level 7 src63");
    exp_rd(8'h08, 32'd127, "R11 sw ack src63");
    wr(8'h05, 32'h0);
    idle(1);
    exp_rd(8'h01, 32'h0004_0100, "R4 force cleared");
    exp_lvl(3'd5, "R4 level back to 5");

    // R5 level 0 source never competes
    set_req(30, 1'b1);
    wr(8'h02, 32'hBFEF_FFF6);
    exp_rd(8'h00, 32'h4010_0008, "R2 pending low three sources");
    exp_lvl(3'd5, "R5 level 0 source ignored");
    exp_rd(8'h08, 32'd114, "R5 sw ack unchanged");

    // R7 / R10 requests removed
    @(negedge clk) irq_req = '0;
    exp_lvl(3'd0, "R7 no requests");
    exp_rd(8'h0D, 32'd24, "R10 level 5 spurious");
    exp_rd(8'h08, 32'd24, "R11 sw ack spurious");
    exp_rd(8'h00, 32'h0, "R2 pending follows request");

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule